// File: doc/BRIEF.md
# Clock Output Gating and Stop Controller

This block sits between the clock sources of a system clock generator and its output pins. It decides, for each clock output, whether the output toggles or is held at logic 0. The decision for each output is the AND of its enable bit in a configuration byte and, for the CPU pair and the stoppable PCI group, an active-low stop input. The outputs are the CPU pair, five stoppable PCI clocks, one free-running PCI clock, fourteen SDRAM clocks, a 24 MHz clock and a 48 MHz clock. Each request passes through a synchroniser in the domain of its clock. The request is then applied on a falling edge, so the gated output never shows a shortened high pulse.

Two pins are shared. A strap input is sampled while power-on reset is held. With the strap at 0, the two pins are the CPU stop and PCI stop inputs. With the strap at 1, they carry SDRAM clocks 11 and 10 out, and both stop functions are disabled. The frequency-select strap pins are captured at the same time. A configuration bit chooses between these captured pins and a register field. A further configuration bit drops every output enable, so that all outputs go to high impedance.

Top module: `clkstop_ctrl`

## Requirements
- R1: With the strap latched at 0, a low level on `share_i[0]` holds both `cpu_o` bits low. Every other output keeps its state.
- R2: With the strap latched at 0, a low level on `share_i[1]` holds `pci_o[4:0]` low. `pcif_o` and all other outputs keep toggling.
- R3: The strap `mode_i` is captured only while `por_n` is low. If it is 1, `share_oe` is 1 (unless R8 applies) and `share_o[0]`/`share_o[1]` carry SDRAM clocks 11/10, which are otherwise held low. Both stop inputs are then ignored. Changes of `mode_i` after reset have no effect.
- R4: In `cfg_cpu`, bit 0 enables `cpu_o[0]`, bit 1 enables `cpu_o[1]`, bit 2 enables `sdram_o[13]` and bit 3 enables `sdram_o[12]`. A value of 0 holds the output low.
- R5: In `cfg_pci`, bits 0..4 enable `pci_o[0..4]` and bit 6 enables `pcif_o`.
- R6: In `cfg_sdram`, bit g (g = 0..2) enables `sdram_o[4g+3:4g]`, bit 4 enables `c24_o` and bit 5 enables `c48_o`.
- R7: A changed request reaches the output on the third rising edge of the source clock after it is sampled. A stopped output drops to low only after a full high phase, and every high pulse lasts exactly half a source period.
- R8: `cfg_fn` bit 0 at 1 drives `out_oe` and `share_oe` to 0. At 0, `out_oe` is 1.
- R9: `fs_o` equals the `fs_i` value captured during reset while `cfg_fn` bit 3 is 0. It equals `cfg_fn[6:4]` while that bit is 1.
- R10: While `por_n` is low, every clock output is low. After release, with all enable bits set, every enabled output toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock used to capture the straps |
| cpu_clk | input | 1 | Source for the CPU outputs |
| pci_clk | input | 1 | Source for the PCI outputs |
| sdram_clk | input | 1 | Buffer input feeding the SDRAM outputs |
| clk24 | input | 1 | 24 MHz source |
| clk48 | input | 1 | 48 MHz source |
| por_n | input | 1 | Power-on reset, active low |
| mode_i | input | 1 | Pin-sharing strap |
| fs_i | input | 3 | Frequency-select straps |
| cfg_fn | input | 8 | Function byte: bit 0 tristate, bit 3 select source, bits 6:4 select value |
| cfg_cpu | input | 8 | CPU and upper SDRAM enables |
| cfg_pci | input | 8 | PCI enables |
| cfg_sdram | input | 8 | SDRAM group and 24/48 MHz enables |
| share_i | input | 2 | Shared pins as inputs: [0] CPU stop, [1] PCI stop |
| cpu_o | output | 2 | Gated CPU clocks |
| pci_o | output | 5 | Gated stoppable PCI clocks |
| pcif_o | output | 1 | Gated free-running PCI clock |
| sdram_o | output | 14 | Gated SDRAM clocks |
| c24_o | output | 1 | Gated 24 MHz clock |
| c48_o | output | 1 | Gated 48 MHz clock |
| share_o | output | 2 | Shared pins as outputs: [0] SDRAM 11, [1] SDRAM 10 |
| share_oe | output | 1 | Drive enable for the shared pins |
| out_oe | output | 1 | Drive enable for all dedicated outputs |
| fs_o | output | 3 | Selected frequency code |

## Verification
Two things can act on the same output in the same cycle: a stop pin and that output's enable bit. The latched strap decides whether the stop pin is heard at all. The bench sweeps every single-bit enable pattern, plus all-ones and all-zeros, against all four stop-pin combinations in both strap modes. It then compares the per-output activity, measured over a window, with a vector computed from the requirements. A separate edge-counting test and a pulse-width monitor check that a stop and a restart landing on a running clock never produce a shortened pulse.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    localparam int NUM_CPU       = 2;
    localparam int NUM_PCI       = 5;
    localparam int SDRAM_GRP     = 4;
    localparam int NUM_SDRAM_GRP = 3;
    localparam int NUM_SDRAM     = NUM_SDRAM_GRP * SDRAM_GRP + 2;
    localparam int SDRAM_HI_A    = NUM_SDRAM_GRP * SDRAM_GRP;      // enabled by cfg_cpu[3]
    localparam int SDRAM_HI_B    = SDRAM_HI_A + 1;                 // enabled by cfg_cpu[2]
    localparam int SDRAM_SHR_LO  = 10;                             // shared pin pair 10/11
    localparam int FS_W          = 3;
    localparam int STRAP_W       = FS_W + 1;

    // function byte bit positions
    localparam int FN_TRI   = 0;
    localparam int FN_FSSRC = 3;
    localparam int FN_FSLO  = 4;
    // enable byte bit positions
    localparam int PCI_FREE = 6;
    localparam int SD_C24   = 4;
    localparam int SD_C48   = 5;
    localparam int CPU_SDA  = 3;
    localparam int CPU_SDB  = 2;

    typedef struct packed {
        logic [NUM_CPU-1:0]   cpu;
        logic [NUM_PCI-1:0]   pci;
        logic                 pcif;
        logic [NUM_SDRAM-1:0] sdram;
        logic                 c24;
        logic                 c48;
    } clk_en_t;

    typedef struct packed {
        logic            mode;
        logic [FS_W-1:0] fs;
    } strap_t;
endpackage

// File: rtl/clkstop_strap.sv
module clkstop_strap #(
    parameter int W = 4
) (
    input  logic         ref_clk,
    input  logic         por_n,
    input  logic [W-1:0] strap_i,
    output logic [W-1:0] strap_o
);
    logic [W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (!por_n) begin
            cap_d = strap_i;
        end
    end

    always_ff @(posedge ref_clk) begin
        cap_q <= cap_d;
    end

    assign strap_o = cap_q;

    AST_STRAP_HOLD: assert property (@(posedge ref_clk) disable iff (!por_n)
        $past(por_n) |-> $stable(strap_o)); // R3
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic clk_o
);
    localparam int CW = $clog2(SYNC_STAGES + 2);
    localparam logic [CW-1:0] SETTLE = CW'(SYNC_STAGES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  gate_d, gate_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.sync = SYNC_STAGES'({sync_q.sync, en_i});
        gate_d      = sync_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    // enable changes only on the falling edge, while the clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= gate_d;
    end

    assign clk_o = clk_i & gate_q;

    // run-length counters of the raw request, used by the checks below
    logic [CW-1:0] lo_run_q, hi_run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_run_q <= '0;
            hi_run_q <= '0;
        end else begin
            lo_run_q <= en_i ? '0 : ((lo_run_q == SETTLE) ? lo_run_q : lo_run_q + 1'b1);
            hi_run_q <= !en_i ? '0 : ((hi_run_q == SETTLE) ? hi_run_q : hi_run_q + 1'b1);
        end
    end

    AST_HOLD_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (lo_run_q == SETTLE) |-> !clk_o); // R7
    AST_RESUME: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (hi_run_q == SETTLE) |-> clk_o); // R7
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 ref_clk,
    input  logic                 cpu_clk,
    input  logic                 pci_clk,
    input  logic                 sdram_clk,
    input  logic                 clk24,
    input  logic                 clk48,
    input  logic                 por_n,
    input  logic                 mode_i,
    input  logic [FS_W-1:0]      fs_i,
    input  logic [7:0]           cfg_fn,
    input  logic [7:0]           cfg_cpu,
    input  logic [7:0]           cfg_pci,
    input  logic [7:0]           cfg_sdram,
    input  logic [1:0]           share_i,
    output logic [NUM_CPU-1:0]   cpu_o,
    output logic [NUM_PCI-1:0]   pci_o,
    output logic                 pcif_o,
    output logic [NUM_SDRAM-1:0] sdram_o,
    output logic                 c24_o,
    output logic                 c48_o,
    output logic [1:0]           share_o,
    output logic                 share_oe,
    output logic                 out_oe,
    output logic [FS_W-1:0]      fs_o
);
    strap_t  strap_in, strap_q;
    clk_en_t en;
    logic    cpu_run, pci_run;

    assign strap_in.mode = mode_i;
    assign strap_in.fs   = fs_i;

    clkstop_strap #(.W(STRAP_W)) u_strap (
        .ref_clk (ref_clk),
        .por_n   (por_n),
        .strap_i (strap_in),
        .strap_o (strap_q)
    );

    always_comb begin
        en      = '0;
        cpu_run = strap_q.mode | share_i[0];
        pci_run = strap_q.mode | share_i[1];
        en.cpu  = cfg_cpu[NUM_CPU-1:0] & {NUM_CPU{cpu_run}};
        en.pci  = cfg_pci[NUM_PCI-1:0] & {NUM_PCI{pci_run}};
        en.pcif = cfg_pci[PCI_FREE];
        for (int k = 0; k < NUM_SDRAM_GRP * SDRAM_GRP; k++) begin
            en.sdram[k] = cfg_sdram[k / SDRAM_GRP];
        end
        en.sdram[SDRAM_HI_A]     = cfg_cpu[CPU_SDA];
        en.sdram[SDRAM_HI_B]     = cfg_cpu[CPU_SDB];
        en.sdram[SDRAM_SHR_LO]   = en.sdram[SDRAM_SHR_LO]   & strap_q.mode;
        en.sdram[SDRAM_SHR_LO+1] = en.sdram[SDRAM_SHR_LO+1] & strap_q.mode;
        en.c24  = cfg_sdram[SD_C24];
        en.c48  = cfg_sdram[SD_C48];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CPU; gi++) begin : g_cpu
            clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
                .clk_i (cpu_clk), .rst_ni (por_n), .en_i (en.cpu[gi]), .clk_o (cpu_o[gi]));
        end
        for (gi = 0; gi < NUM_PCI; gi++) begin : g_pci
            clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
                .clk_i (pci_clk), .rst_ni (por_n), .en_i (en.pci[gi]), .clk_o (pci_o[gi]));
        end
        for (gi = 0; gi < NUM_SDRAM; gi++) begin : g_sdram
            clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
                .clk_i (sdram_clk), .rst_ni (por_n), .en_i (en.sdram[gi]), .clk_o (sdram_o[gi]));
        end
    endgenerate

    clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_pcif (
        .clk_i (pci_clk), .rst_ni (por_n), .en_i (en.pcif), .clk_o (pcif_o));
    clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_c24 (
        .clk_i (clk24), .rst_ni (por_n), .en_i (en.c24), .clk_o (c24_o));
    clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_c48 (
        .clk_i (clk48), .rst_ni (por_n), .en_i (en.c48), .clk_o (c48_o));

    assign share_o  = {sdram_o[SDRAM_SHR_LO], sdram_o[SDRAM_SHR_LO+1]};
    assign out_oe   = ~cfg_fn[FN_TRI];
    assign share_oe = strap_q.mode & ~cfg_fn[FN_TRI];
    assign fs_o     = cfg_fn[FN_FSSRC] ? cfg_fn[FN_FSLO +: FS_W] : strap_q.fs;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_fn[7], cfg_fn[2:1], cfg_cpu[7:4], cfg_pci[7],
                               cfg_pci[5], cfg_sdram[7:6], cfg_sdram[3]};

    AST_SHARE_OE_TRI: assert property (@(posedge ref_clk) disable iff (!por_n)
        share_oe |-> out_oe); // R8
    AST_FS_STRAP_HOLD: assert property (@(posedge ref_clk) disable iff (!por_n)
        (!cfg_fn[FN_FSSRC] && $stable(cfg_fn[FN_FSSRC])) |-> $stable(fs_o)); // R9
endmodule

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/100ps
module tb_clkstop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CPU_HALF = CLK_PERIOD / 2;
    localparam int SD_HALF  = 7;
    localparam int PCI_HALF = 3 * CPU_HALF;
    localparam int C48_HALF = 2 * CPU_HALF;
    localparam int C24_HALF = 4 * CPU_HALF;
    localparam int REF_HALF = 35;
    localparam int WD_NS    = 1500000;

    logic ref_clk = 0, cpu_clk = 0, pci_clk = 0, sdram_clk = 0, clk24 = 0, clk48 = 0;
    logic por_n;
    logic mode_i = 0;
    logic [2:0] fs_i = 3'd5;
    logic [7:0] cfg_fn = 8'h00, cfg_cpu = 8'hFF, cfg_pci = 8'hFF, cfg_sdram = 8'hFF;
    logic [1:0] share_i = 2'b11;
    logic [1:0] cpu_o;
    logic [4:0] pci_o;
    logic pcif_o, c24_o, c48_o, share_oe, out_oe;
    logic [13:0] sdram_o;
    logic [1:0] share_o;
    logic [2:0] fs_o;

    int tests = 0, fails = 0, runts = 0;
    bit done = 0;

    always #(REF_HALF) ref_clk = ~ref_clk;
    always #(CPU_HALF) cpu_clk = ~cpu_clk;
    always #(PCI_HALF) pci_clk = ~pci_clk;
    always #(SD_HALF)  sdram_clk = ~sdram_clk;
    always #(C24_HALF) clk24 = ~clk24;
    always #(C48_HALF) clk48 = ~clk48;

    clkstop_ctrl dut (
        .ref_clk(ref_clk), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdram_clk(sdram_clk),
        .clk24(clk24), .clk48(clk48), .por_n(por_n), .mode_i(mode_i), .fs_i(fs_i),
        .cfg_fn(cfg_fn), .cfg_cpu(cfg_cpu), .cfg_pci(cfg_pci), .cfg_sdram(cfg_sdram),
        .share_i(share_i), .cpu_o(cpu_o), .pci_o(pci_o), .pcif_o(pcif_o),
        .sdram_o(sdram_o), .c24_o(c24_o), .c48_o(c48_o), .share_o(share_o),
        .share_oe(share_oe), .out_oe(out_oe), .fs_o(fs_o));

    // bit layout: [1:0] cpu, [6:2] pci, [7] pcif, [21:8] sdram, [22] c24, [23] c48, [25:24] share
    logic [25:0] obs;
    assign obs = {share_o, c48_o, c24_o, sdram_o, pcif_o, pci_o, cpu_o};

    // R7: high pulse width monitors
    time t_cpu = 0, t_pci = 0, t_c24 = 0;
    bit  v_cpu = 0, v_pci = 0, v_c24 = 0;
    always @(posedge cpu_o[0]) begin t_cpu = $time; v_cpu = por_n; end
    always @(negedge cpu_o[0]) if (v_cpu && por_n && ($time - t_cpu != CPU_HALF)) runts++;
    always @(posedge pci_o[0]) begin t_pci = $time; v_pci = por_n; end
    always @(negedge pci_o[0]) if (v_pci && por_n && ($time - t_pci != PCI_HALF)) runts++;
    always @(posedge c24_o)    begin t_c24 = $time; v_c24 = por_n; end
    always @(negedge c24_o)    if (v_c24 && por_n && ($time - t_c24 != C24_HALF)) runts++;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [25:0] expect_run(input logic [7:0] b1, input logic [7:0] b2,
                                               input logic [7:0] b3, input logic md,
                                               input logic [1:0] st);
        logic [25:0] e;
        logic cr, pr;
        e  = '0;
        cr = md | st[0];
        pr = md | st[1];
        e[0] = b1[0] & cr;
        e[1] = b1[1] & cr;
        for (int i = 0; i < 5; i++) e[2+i] = b2[i] & pr;
        e[7] = b2[6];
        for (int k = 0; k < 12; k++) e[8+k] = b3[k/4];
        e[20] = b1[3];
        e[21] = b1[2];
        e[18] = e[18] & md;
        e[19] = e[19] & md;
        e[22] = b3[4];
        e[23] = b3[5];
        e[24] = e[19];
        e[25] = e[18];
        return e;
    endfunction

    // measure activity: bit toggles (>=2 rises) and whether it was ever high
    task automatic measure(output logic [25:0] act, output logic [25:0] seen);
        int rises [26];
        logic [25:0] prev;
        for (int b = 0; b < 26; b++) rises[b] = 0;
        seen = '0;
        #0.5;
        prev = obs;
        for (int n = 0; n < 400; n++) begin
            #1;
            for (int b = 0; b < 26; b++) if (obs[b] && !prev[b]) rises[b]++;
            seen = seen | obs;
            prev = obs;
        end
        for (int b = 0; b < 26; b++) act[b] = (rises[b] >= 2);
        #0.5;
    endtask

    task automatic do_reset(input logic md);
        logic [25:0] act, seen;
        por_n   = 0;
        mode_i  = md;
        fs_i    = 3'd5;
        cfg_fn  = 8'h00;
        cfg_cpu = 8'hFF; cfg_pci = 8'hFF; cfg_sdram = 8'hFF;
        share_i = 2'b11;
        #300;
        measure(act, seen);
        check("R10 outputs low in reset", {6'd0, seen}, 32'd0);
        @(negedge ref_clk);
        por_n = 1;
        #250;
        measure(act, seen);
        check("R10 all enabled run after reset", {6'd0, act}, {6'd0, expect_run(8'hFF, 8'hFF, 8'hFF, md, 2'b11)});
    endtask

    initial begin
        #(WD_NS);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [25:0] act, seen, exp;
        logic [7:0] b1, b2, b3;
        string tag;
        int hi1, hi2, hi3;

        for (int md = 0; md < 2; md++) begin
            do_reset(md[0]);
            for (int pat = 0; pat < 26; pat++) begin
                b1 = 8'hFF; b2 = 8'hFF; b3 = 8'hFF;
                if (pat < 8)       b1[pat] = 1'b0;
                else if (pat < 16) b2[pat-8] = 1'b0;
                else if (pat < 24) b3[pat-16] = 1'b0;
                else if (pat == 25) begin b1 = 8'h00; b2 = 8'h00; b3 = 8'h00; end
                for (int st = 0; st < 4; st++) begin
                    cfg_cpu = b1; cfg_pci = b2; cfg_sdram = b3;
                    share_i = st[1:0];
                    if (md == 1)       tag = "R3 stop ignored, shared pins out";
                    else if (st != 3)  tag = "R1/R2 stop pins";
                    else if (pat < 8)  tag = "R4 cpu byte";
                    else if (pat < 16) tag = "R5 pci byte";
                    else               tag = "R6 sdram byte";
                    #250;
                    measure(act, seen);
                    exp = expect_run(b1, b2, b3, md[0], st[1:0]);
                    // running outputs toggle; stopped outputs never high
                    check(tag, {4'd0, share_oe, out_oe, act | (seen & ~exp)}, {4'd0, md[0], 1'b1, exp});
                end
            end
        end

        // still in strap mode 1: later strap changes ignored (R3)
        cfg_cpu = 8'hFF; cfg_pci = 8'hFF; cfg_sdram = 8'hFF; share_i = 2'b00;
        mode_i = 1'b0;
        #500;
        check("R3 strap change after reset ignored", {31'd0, share_oe}, 32'd1);

        // R8 tristate
        cfg_fn = 8'h01; #1;
        check("R8 tristate drops enables", {30'd0, out_oe, share_oe}, 32'd0);
        cfg_fn = 8'h00; #1;
        check("R8 tristate released", {30'd0, out_oe, share_oe}, 32'd3);

        // R9 frequency-select source
        fs_i = 3'd2; #200;
        check("R9 latched fs kept", {29'd0, fs_o}, 32'd5);
        cfg_fn = 8'b0110_1000; #1;
        check("R9 register fs used", {29'd0, fs_o}, 32'd6);
        cfg_fn = 8'b0110_0000; #1;
        check("R9 back to latched fs", {29'd0, fs_o}, 32'd5);
        cfg_fn = 8'h00;

        // R7 latency and glitch-free stop/restart on CPU clock
        do_reset(1'b0);
        @(posedge cpu_clk); #1 share_i[0] = 1'b0;
        @(posedge cpu_clk); #1 hi1 = cpu_o[0];
        @(posedge cpu_clk); #1 hi2 = cpu_o[0];
        @(posedge cpu_clk); #1 hi3 = cpu_o[0];
        check("R7 stop takes third edge", {29'd0, hi1[0], hi2[0], hi3[0]}, 32'b110);
        share_i[0] = 1'b1;
        @(posedge cpu_clk); #1 hi1 = cpu_o[0];
        @(posedge cpu_clk); #1 hi2 = cpu_o[0];
        @(posedge cpu_clk); #1 hi3 = cpu_o[0];
        check("R7 restart on third edge", {29'd0, hi1[0], hi2[0], hi3[0]}, 32'b001);
        // PCI stop and restart mid-phase
        #3 share_i[1] = 1'b0;
        #400 share_i[1] = 1'b1;
        #400;
        check("R7 no shortened high pulse", runts, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule